// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block fills the two threshold registers that a FIFO's partial-flag logic compares against: an empty-side offset (`x_o`) and a full-side offset (`y_o`), each `OFS_W` bits wide. While master reset is held low, a serial-mode select pin and two dual-purpose configuration pins pick one of three loading methods. The first method applies a fixed preset. The second takes two writes from the Port A data bus. The third takes a single serial bit stream.

Once master reset is released, the two configuration pins change role. One becomes an active-low serial enable and the other becomes serial data. Both are sampled on the Port A clock. The serial stream fills the concatenation {Y, X} with the most significant bit first, so Y is filled before X. A done output tells the flag logic that the offsets are valid. A partial reset freezes programming but keeps the method, the offsets and any progress already made.

Top module: `ofs_prog`

## Requirements
- R1: After `rst_ni` is asserted, `x_o` and `y_o` are 0 and `done_o` is 0.
- R2: The method is latched on every clock edge while `mrst_ni` is low. With `ser_mode_ni` low, serial is chosen. With `ser_mode_ni` high, {`cfg_hi_en_ni`,`cfg_lo_dat_i`} = 00 chooses parallel, 01 chooses preset 8, 10 chooses preset 16 and 11 chooses preset 64.
- R3: In a preset mode, `x_o` and `y_o` both equal the chosen preset when master reset is released, and `done_o` is 1. `done_o` is 0 while `mrst_ni` is low.
- R4: In serial mode, each clock edge with `mrst_ni` and `prst_ni` high and `cfg_hi_en_ni` low shifts `cfg_lo_dat_i` into the LSB of {Y,X}. The first bit therefore ends in the Y MSB and the last bit ends in the X LSB. With `cfg_hi_en_ni` high, nothing shifts.
- R5: In serial mode, `done_o` rises in the cycle after exactly 2*`OFS_W` bits have been accepted, and not before.
- R6: In parallel mode, the first clock edge with `load_i` high stores `wdata_i` in X. The second stores it in Y and sets `done_o`.
- R7: Once `done_o` is 1, further serial bits and load strobes leave X and Y unchanged.
- R8: While `prst_ni` is low, no bit shifts and no load is taken. X, Y, `done_o`, the method and the progress all hold.
- R9: A master reset in serial or parallel mode clears X, Y and `done_o` and restarts programming from the first bit or the first write.
- R10: The inputs of the method that is not selected have no effect. Load strobes are ignored in serial mode, and serial bits are ignored in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port A clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| mrst_ni | input | 1 | Master reset, synchronous, active low |
| prst_ni | input | 1 | Partial reset, synchronous, active low |
| ser_mode_ni | input | 1 | Serial method select during master reset, active low |
| cfg_hi_en_ni | input | 1 | Preset select high bit during master reset; active-low serial enable afterwards |
| cfg_lo_dat_i | input | 1 | Preset select low bit during master reset; serial data afterwards |
| load_i | input | 1 | Parallel load strobe |
| wdata_i | input | OFS_W | Port A data for parallel loads |
| x_o | output | OFS_W | Empty-side offset |
| y_o | output | OFS_W | Full-side offset |
| done_o | output | 1 | Offsets fully programmed |

## Verification
A wrong latched method would show up in the first cycle after master reset is released. The offsets would be non-zero, or `done_o` would be high, where a serial or parallel load was expected, and that cycle is checked directly. A bit counter that is off by one would move `done_o` by one bit. It would also misalign the final {Y,X} word by one position, so both the done timing and the word are compared after the last bit. A broken freeze on done or on partial reset would change an offset on the very next edge. The bench looks for that one cycle after sending extra stimulus.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
  typedef enum logic [1:0] {
    METH_SER = 2'd0,
    METH_PAR = 2'd1,
    METH_DEF = 2'd2
  } meth_e;

  function automatic int unsigned preset_val(input logic [1:0] code);
    case (code)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ofs_meth_latch.sv
module ofs_meth_latch
  import ofs_prog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mrst_ni,
  input  logic       ser_mode_ni,
  input  logic [1:0] sel_i,
  output meth_e      meth_d_o,
  output meth_e      meth_q_o
);
  meth_e meth_q;

  always_comb begin
    if (!ser_mode_ni)        meth_d_o = METH_SER;
    else if (sel_i == 2'b00) meth_d_o = METH_PAR;
    else                     meth_d_o = METH_DEF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       meth_q <= METH_SER;
    else if (!mrst_ni) meth_q <= meth_d_o;
  end

  assign meth_q_o = meth_q;
endmodule

// File: rtl/ofs_ser_ctl.sv
module ofs_ser_ctl #(
  parameter int unsigned BITS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_ni,
  input  logic prst_ni,
  input  logic active_i,
  input  logic en_ni,
  output logic shift_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(BITS + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign shift_o = active_i & mrst_ni & prst_ni & ~en_ni & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!mrst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (shift_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(BITS - 1)) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/ofs_par_ctl.sv
module ofs_par_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_ni,
  input  logic prst_ni,
  input  logic active_i,
  input  logic load_i,
  output logic ld_x_o,
  output logic ld_y_o,
  output logic done_o
);
  logic second_q, done_q, take;

  assign take   = active_i & mrst_ni & prst_ni & load_i & ~done_q;
  assign ld_x_o = take & ~second_q;
  assign ld_y_o = take & second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (!mrst_ni) begin
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (ld_x_o) second_q <= 1'b1;
      if (ld_y_o) done_q   <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/ofs_prog.sv
module ofs_prog
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrst_ni,
  input  logic             prst_ni,
  input  logic             ser_mode_ni,
  input  logic             cfg_hi_en_ni,
  input  logic             cfg_lo_dat_i,
  input  logic             load_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] x_o,
  output logic [OFS_W-1:0] y_o,
  output logic             done_o
);
  localparam int unsigned WORD_W = 2 * OFS_W;

  meth_e            meth_d, meth_q;
  logic             shift, ser_done, ld_x, ld_y, par_done;
  logic [OFS_W-1:0] x_q, y_q, preset;
  logic [WORD_W-1:0] word_sh;

  ofs_meth_latch u_meth (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mrst_ni    (mrst_ni),
    .ser_mode_ni(ser_mode_ni),
    .sel_i      ({cfg_hi_en_ni, cfg_lo_dat_i}),
    .meth_d_o   (meth_d),
    .meth_q_o   (meth_q)
  );

  ofs_ser_ctl #(.BITS(WORD_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mrst_ni (mrst_ni),
    .prst_ni (prst_ni),
    .active_i(meth_q == METH_SER),
    .en_ni   (cfg_hi_en_ni),
    .shift_o (shift),
    .done_o  (ser_done)
  );

  ofs_par_ctl u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mrst_ni (mrst_ni),
    .prst_ni (prst_ni),
    .active_i(meth_q == METH_PAR),
    .load_i  (load_i),
    .ld_x_o  (ld_x),
    .ld_y_o  (ld_y),
    .done_o  (par_done)
  );

  // preset only applies when the decoded method is default; else clear
  assign preset  = (meth_d == METH_DEF)
                 ? OFS_W'(preset_val({cfg_hi_en_ni, cfg_lo_dat_i})) : '0;
  assign word_sh = {y_q[OFS_W-2:0], x_q, cfg_lo_dat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (!mrst_ni) begin
      x_q <= preset;
      y_q <= preset;
    end else if (shift) begin
      y_q <= word_sh[WORD_W-1:OFS_W];
      x_q <= word_sh[OFS_W-1:0];
    end else begin
      if (ld_x) x_q <= wdata_i;
      if (ld_y) y_q <= wdata_i;
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign done_o = mrst_ni & ((meth_q == METH_DEF) | ser_done | par_done);
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int unsigned OFS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mrst_ni,
  input logic             prst_ni,
  input logic             cfg_hi_en_ni,
  input logic             load_i,
  input logic [OFS_W-1:0] x_o,
  input logic [OFS_W-1:0] y_o,
  input logic             done_o
);
  // R3: preset exit gives equal offsets of an allowed value
  a_r3_preset_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mrst_ni) && done_o) |-> (x_o == y_o) &&
      (x_o == OFS_W'(8) || x_o == OFS_W'(16) || x_o == OFS_W'(64)));

  // R3: no done while master reset held
  a_r3_done_low_in_mrst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_ni |-> !done_o);

  // R9: non-preset exit starts from cleared offsets
  a_r9_cleared_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mrst_ni) && !done_o) |-> (x_o == '0) && (y_o == '0));

  a_r7_frozen_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mrst_ni) |=> $stable(x_o) && $stable(y_o));

  a_r8_prst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prst_ni && mrst_ni) |=> $stable(x_o) && $stable(y_o) && $stable(done_o));

  a_r4_no_shift_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_ni && cfg_hi_en_ni && !load_i) |=> $stable(x_o) && $stable(y_o));

  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> !mrst_ni);
endmodule

bind ofs_prog ofs_prog_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_ofs_prog.sv
`timescale 1ns/1ps
module tb_ofs_prog;
  localparam int unsigned W = 10;
  localparam int unsigned WW = 2 * W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mrst_ni = 1'b1, prst_ni = 1'b1, ser_mode_ni = 1'b1;
  logic         cfg_hi_en_ni = 1'b1, cfg_lo_dat_i = 1'b0, load_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] x_o, y_o;
  logic         done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  ofs_prog #(.OFS_W(W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic mreset(input logic sm, input logic hi, input logic lo);
    mrst_ni = 1'b0; ser_mode_ni = sm; cfg_hi_en_ni = hi; cfg_lo_dat_i = lo;
    repeat (4) tick();
    chk("R3 done low in mrst", done_o, 0);
    mrst_ni = 1'b1; cfg_hi_en_ni = 1'b1; cfg_lo_dat_i = 1'b0; load_i = 1'b0;
    tick();
  endtask

  task automatic send_bit(input logic b);
    cfg_hi_en_ni = 1'b0; cfg_lo_dat_i = b; tick();
    cfg_hi_en_ni = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 x", x_o, 0); chk("R1 y", y_o, 0); chk("R1 done", done_o, 0);
  endtask

  task automatic t_default(input logic [1:0] code, input int val);
    mreset(1'b1, code[1], code[0]);
    chk("R2/R3 preset x", x_o, val);
    chk("R2/R3 preset y", y_o, val);
    chk("R3 done", done_o, 1);
  endtask

  task automatic t_serial(input logic [WW-1:0] word);
    mreset(1'b0, 1'b1, 1'b0);
    chk("R9 x cleared", x_o, 0); chk("R9 done cleared", done_o, 0);
    for (int i = 0; i < WW; i++) begin
      send_bit(word[WW-1-i]);
      if (i == 5) begin  // R4: disabled cycle with toggled data
        cfg_lo_dat_i = ~word[WW-1-i]; tick();
      end
      if (i == 7) begin  // R10: load strobe ignored in serial mode
        load_i = 1'b1; wdata_i = 10'h3FF; tick(); load_i = 1'b0;
      end
      if (i == WW - 2) chk("R5 not done early", done_o, 0);
    end
    chk("R4 y word", y_o, int'(word[WW-1:W]));
    chk("R4 x word", x_o, int'(word[W-1:0]));
    chk("R5 done", done_o, 1);
    for (int i = 0; i < 3; i++) send_bit(~word[i]);
    load_i = 1'b1; wdata_i = 10'h155; tick(); load_i = 1'b0;
    chk("R7 y frozen", y_o, int'(word[WW-1:W]));
    chk("R7 x frozen", x_o, int'(word[W-1:0]));
  endtask

  task automatic t_prst_serial(input logic [WW-1:0] word);
    mreset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < WW / 2; i++) send_bit(word[WW-1-i]);
    prst_ni = 1'b0; cfg_hi_en_ni = 1'b0; cfg_lo_dat_i = 1'b1;
    repeat (2) tick();
    prst_ni = 1'b1; cfg_hi_en_ni = 1'b1;
    for (int i = WW / 2; i < WW; i++) send_bit(word[WW-1-i]);
    chk("R8 y after freeze", y_o, int'(word[WW-1:W]));
    chk("R8 x after freeze", x_o, int'(word[W-1:0]));
    chk("R8 done", done_o, 1);
    prst_ni = 1'b0; repeat (2) tick(); prst_ni = 1'b1; tick();
    chk("R8 done kept", done_o, 1);
    chk("R8 x kept", x_o, int'(word[W-1:0]));
  endtask

  task automatic t_parallel();
    mreset(1'b1, 1'b0, 1'b0);
    chk("R2 parallel not done", done_o, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    chk("R10 serial ignored x", x_o, 0);
    chk("R10 serial ignored y", y_o, 0);
    load_i = 1'b1; wdata_i = 10'h12A; tick(); load_i = 1'b0;
    chk("R6 x first", x_o, 'h12A); chk("R6 y untouched", y_o, 0);
    chk("R6 not done", done_o, 0);
    prst_ni = 1'b0; load_i = 1'b1; wdata_i = 10'h0F0; tick();
    prst_ni = 1'b1; load_i = 1'b0;
    chk("R8 load blocked y", y_o, 0); chk("R8 x held", x_o, 'h12A);
    load_i = 1'b1; wdata_i = 10'h2B7; tick(); load_i = 1'b0;
    chk("R6 y second", y_o, 'h2B7); chk("R6 done", done_o, 1);
    load_i = 1'b1; wdata_i = 10'h001; tick(); load_i = 1'b0;
    chk("R7 x frozen", x_o, 'h12A); chk("R7 y frozen", y_o, 'h2B7);
    mreset(1'b0, 1'b1, 1'b1);
    chk("R9 x cleared", x_o, 0); chk("R9 y cleared", y_o, 0);
    chk("R9 done cleared", done_o, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_default(2'b01, 8);
    t_default(2'b10, 16);
    t_default(2'b11, 64);
    t_serial({10'h2A5, 10'h1C3});
    t_serial({10'h3FF, 10'h001});
    t_prst_serial({10'h0F3, 10'h35A});
    t_parallel();
    t_default(2'b10, 16);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule